// File: doc/BRIEF.md
# Weight-Proportional Particle Resampler

This block performs the resampling step of a hardware particle filter. Once a new set of particle weights sits in a weight memory, a start pulse makes the block read every weight once to form the total. It then draws as many random values as there are particles. Each draw picks one particle with probability proportional to its weight. The block emits the picked indices as a stream, so a heavy particle shows up many times and a light one may not show up at all. A one-cycle done pulse closes the stream. The caller then copies particle states according to the index list.

The block never divides and never normalises. A draw `u` from an internal 16-bit shift-register generator is compared against the running weight sum through cross products: `u * total` is compared with `cum * 2^RW`. This works for any particle count, including counts that are not a power of two. It also does not need the random values in sorted order. The running sum is rebuilt during each draw's scan, so the memory holds only raw weights. A small register buffer keeps the lowest-indexed weights, which every scan starts from. The scan therefore begins in the cycle right after the random value is produced, and the memory reads for higher indices are issued ahead, while the buffer is feeding the compare.

Top module: `rs_resampler`

## Requirements
- R1: During and after reset, `busy_o`, `idx_valid_o` and `done_o` are low and `mem_rd_o` is low.
- R2: A `start_i` seen while idle makes the block read addresses 0 to N_PART-1 in ascending order, one per cycle. Each read returns its data on `mem_data_i` one cycle after the read cycle. The block then emits exactly N_PART indices and raises `done_o` for one cycle, in the cycle after the last index. `busy_o` is high from the cycle after start until `done_o`.
- R3: A `start_i` while busy is ignored. The run in progress still produces exactly N_PART indices with unchanged values.
- R4: Each draw first steps a 16-bit generator: `s <= {s[14:0], ^(s & 16'hB400)}`, starting from the seed 16'hACE1 at reset. The draw value `u` is the new state.
- R5: The emitted index is the smallest j for which `u * T < C_j * 65536`, where T is the sum of all weights and C_j is the sum of weights 0..j. If no j qualifies (all weights zero), the index is N_PART-1.
- R6: When T is nonzero, a particle whose weight is zero is never emitted.
- R7: After the summing pass, weights with index below PF_DEPTH are never read from memory again during the run. They come from the prefetch buffer.
- R8: Two consecutive indices within a run are exactly j+2 cycles apart, where j is the value of the later index.
- R9: The generator is not reseeded between runs. Each run continues the sequence where the previous run stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a resampling run when idle |
| busy_o | output | 1 | A run is in progress |
| mem_rd_o | output | 1 | Weight memory read strobe |
| mem_addr_o | output | AW | Weight memory read address |
| mem_data_i | input | WW | Weight returned one cycle after the read |
| idx_valid_o | output | 1 | `idx_o` carries a selected particle |
| idx_o | output | AW | Selected particle index |
| done_o | output | 1 | One-cycle pulse after the last index of a run |

## Verification
A wrong total or a wrong running sum shows up at once as an index that differs from the one recomputed from the weights and the known random sequence. It can appear as early as the first draw, and it always appears within a run whose weights are skewed. A wrong prefetch buffer entry or a wrong weight source gives wrong indices for draws that land on low indices. A buffer that is not being used at all shows up as memory reads below PF_DEPTH after the summing pass. Faults in control or in the scan counter show up as wrong spacing between indices, as an index count other than N_PART, or as a done pulse that does not follow the last index directly.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SUM      = 2'd1,
    ST_RESAMPLE = 2'd2,
    ST_DONE     = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rs_lfsr.sv
module rs_lfsr #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] state_q;

  assign next_o = {state_q[W-2:0], ^(state_q & TAPS)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= next_o;
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/rs_pf_buf.sv
module rs_pf_buf #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned WW    = 8,
  localparam int unsigned PIW  = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [PIW-1:0] wr_idx_i,
  input  logic [WW-1:0]  wr_data_i,
  input  logic [PIW-1:0] rd_idx_i,
  output logic [WW-1:0]  rd_data_o
);
  logic [WW-1:0] ent_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_idx_i == PIW'(i)) ent_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx_i == PIW'(i)) rd_data_o = ent_q[i];
  end
endmodule

// File: rtl/rs_cmp.sv
module rs_cmp #(
  parameter int unsigned WW = 8,
  parameter int unsigned TW = 12,
  parameter int unsigned RW = 16,
  localparam int unsigned PW = RW + TW
) (
  input  logic [RW-1:0] u_i,
  input  logic [TW-1:0] total_i,
  input  logic [TW-1:0] cum_i,
  input  logic [WW-1:0] w_i,
  output logic [TW-1:0] cum_next_o,
  output logic          hit_o
);
  logic [PW-1:0] lhs, rhs;

  assign cum_next_o = cum_i + TW'(w_i);
  // cross products replace u/2^RW < cum/total
  assign lhs   = PW'(u_i) * PW'(total_i);
  assign rhs   = {cum_next_o, {RW{1'b0}}};
  assign hit_o = lhs < rhs;
endmodule

// File: rtl/rs_resampler.sv
module rs_resampler
  import rs_pkg::*;
#(
  parameter int unsigned   N_PART    = 13,
  parameter int unsigned   WW        = 8,
  parameter int unsigned   RW        = 16,
  parameter int unsigned   PF_DEPTH  = 5,
  parameter logic [RW-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [RW-1:0] LFSR_TAPS = 16'hB400,
  localparam int unsigned  AW = (N_PART > 1) ? $clog2(N_PART) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [WW-1:0] mem_data_i,
  output logic          idx_valid_o,
  output logic [AW-1:0] idx_o,
  output logic          done_o
);
  localparam int unsigned CW  = $clog2(N_PART + 1);
  localparam int unsigned TW  = WW + $clog2(N_PART);
  localparam int unsigned PIW = $clog2(PF_DEPTH + 1);
  localparam logic [CW-1:0] N_C    = CW'(N_PART);
  localparam logic [CW-1:0] LAST_C = CW'(N_PART - 1);
  localparam logic [CW-1:0] PF_C   = CW'(PF_DEPTH);

  rs_state_e      state_q;
  logic [CW-1:0]  issue_q, pend_idx_q, k_q, draw_q;
  logic           pend_q, scan_q;
  logic [TW-1:0]  total_q, cum_q, cum_next;
  logic [RW-1:0]  u_q, lfsr_next;
  logic           idx_valid_q, done_q, cmp_hit, hit;
  logic [AW-1:0]  idx_q;
  logic [WW-1:0]  buf_rd, w_sel;
  logic           rd_en;
  logic [CW-1:0]  rd_addr, k_nxt;
  logic           lfsr_step, buf_wr;

  assign lfsr_step = (state_q == ST_RESAMPLE) && !scan_q;
  assign buf_wr    = (state_q == ST_SUM) && pend_q && (pend_idx_q < PF_C);
  assign k_nxt     = k_q + 1'b1;

  rs_lfsr #(.W(RW), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (lfsr_step),
    .next_o (lfsr_next)
  );

  rs_pf_buf #(.DEPTH(PF_DEPTH), .WW(WW)) u_pf_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (buf_wr),
    .wr_idx_i  (PIW'(pend_idx_q)),
    .wr_data_i (mem_data_i),
    .rd_idx_i  (PIW'(k_q)),
    .rd_data_o (buf_rd)
  );

  // low indices come from the buffer, the rest from reads issued one index ahead
  assign w_sel = (k_q < PF_C) ? buf_rd : mem_data_i;

  rs_cmp #(.WW(WW), .TW(TW), .RW(RW)) u_cmp (
    .u_i        (u_q),
    .total_i    (total_q),
    .cum_i      (cum_q),
    .w_i        (w_sel),
    .cum_next_o (cum_next),
    .hit_o      (cmp_hit)
  );

  assign hit = cmp_hit || (k_q == LAST_C);

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    if (state_q == ST_SUM && issue_q < N_C) begin
      rd_en   = 1'b1;
      rd_addr = issue_q;
    end else if (state_q == ST_RESAMPLE && scan_q && k_nxt >= PF_C && k_nxt < N_C) begin
      rd_en   = 1'b1;
      rd_addr = k_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      issue_q     <= '0;
      pend_q      <= 1'b0;
      pend_idx_q  <= '0;
      total_q     <= '0;
      cum_q       <= '0;
      u_q         <= '0;
      k_q         <= '0;
      draw_q      <= '0;
      scan_q      <= 1'b0;
      idx_valid_q <= 1'b0;
      idx_q       <= '0;
      done_q      <= 1'b0;
    end else begin
      idx_valid_q <= 1'b0;
      done_q      <= (state_q == ST_DONE);
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SUM;
          issue_q <= '0;
          total_q <= '0;
          pend_q  <= 1'b0;
        end
        ST_SUM: begin
          if (rd_en) issue_q <= issue_q + 1'b1;
          pend_q     <= rd_en;
          pend_idx_q <= issue_q;
          if (pend_q) begin
            total_q <= total_q + TW'(mem_data_i);
            if (pend_idx_q == LAST_C) begin
              state_q <= ST_RESAMPLE;
              scan_q  <= 1'b0;
              draw_q  <= '0;
            end
          end
        end
        ST_RESAMPLE: begin
          if (!scan_q) begin
            u_q    <= lfsr_next;
            k_q    <= '0;
            cum_q  <= '0;
            scan_q <= 1'b1;
          end else if (hit) begin
            idx_valid_q <= 1'b1;
            idx_q       <= AW'(k_q);
            scan_q      <= 1'b0;
            draw_q      <= draw_q + 1'b1;
            if (draw_q == LAST_C) state_q <= ST_DONE;
          end else begin
            k_q   <= k_nxt;
            cum_q <= cum_next;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_rd_o    = rd_en;
  assign mem_addr_o  = AW'(rd_addr);
  assign idx_valid_o = idx_valid_q;
  assign idx_o       = idx_q;
  assign done_o      = done_q;

  // R5
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_valid_o |-> (CW'(idx_o) < N_C));
  // R7
  pf_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESAMPLE && mem_rd_o) |-> (CW'(mem_addr_o) >= PF_C));
  // R2
  done_after_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(idx_valid_o));
  // R8
  idx_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_valid_o |=> !idx_valid_o);
  // R3
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESAMPLE) |=> (state_q == ST_RESAMPLE || state_q == ST_DONE));
endmodule

// File: tb/rs_resampler_test.sv
`timescale 1ns/1ps
module rs_resampler_test;
  localparam int N  = 13;
  localparam int PF = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       busy_o, mem_rd_o, idx_valid_o, done_o;
  logic [3:0] mem_addr_o, idx_o;
  logic [7:0] mem_data_i = '0;

  int checks = 0;
  int errors = 0;
  int wts [N];
  logic [15:0] ref_s = 16'hACE1;

  always #2.5 clk = ~clk;

  always @(posedge clk)
    if (mem_rd_o && int'(mem_addr_o) < N) mem_data_i <= 8'(wts[mem_addr_o]);

  rs_resampler uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .idx_valid_o(idx_valid_o), .idx_o(idx_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 R5 R9: reference draw, generator state carried across runs
  function automatic int ref_draw();
    longint t = 0, cum = 0, u;
    int sel = N - 1;
    bit found = 0;
    ref_s = {ref_s[14:0], ^(ref_s & 16'hB400)};
    u = longint'(ref_s);
    for (int i = 0; i < N; i++) t += wts[i];
    for (int j = 0; j < N; j++) begin
      cum += wts[j];
      if (!found && (u * t < cum * 65536)) begin sel = j; found = 1; end
    end
    return sel;
  endfunction

  task automatic run_case(input string name, input bit restart);
    int exp_idx [N];
    int got_cyc [N];
    int n_got = 0, n_rd = 0, cyc = 0, done_cyc = -1, done_cnt = 0;
    bit sum_over = 0;
    for (int d = 0; d < N; d++) exp_idx[d] = ref_draw();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o, "R2 busy after start", int'(busy_o), 1);
    while (cyc < 2000) begin
      if (restart && n_got == 3) start_i = 1'b1; else start_i = 1'b0;
      if (mem_rd_o) begin
        if (!sum_over) begin
          // R2 ascending summing reads
          if (int'(mem_addr_o) != n_rd) chk(0, "R2 sum read order", int'(mem_addr_o), n_rd);
          n_rd++;
          if (int'(mem_addr_o) == N - 1) sum_over = 1;
        end else if (int'(mem_addr_o) < PF) begin
          chk(0, "R7 buffered weight re-read", int'(mem_addr_o), PF);
        end
      end
      if (idx_valid_o) begin
        if (n_got < N) begin
          chk(int'(idx_o) == exp_idx[n_got], {"R5 index ", name}, int'(idx_o), exp_idx[n_got]);
          got_cyc[n_got] = cyc;
          if (n_got > 0)
            chk(cyc - got_cyc[n_got-1] == exp_idx[n_got] + 2, "R8 spacing",
                cyc - got_cyc[n_got-1], exp_idx[n_got] + 2);
        end
        n_got++;
      end
      if (done_o) begin done_cnt++; if (done_cyc < 0) done_cyc = cyc; end
      if (done_cnt > 0 && !busy_o && !done_o) break;
      @(negedge clk); cyc++;
    end
    start_i = 1'b0;
    if (cyc >= 2000) chk(0, "watchdog", cyc, 2000);
    chk(n_got == N, {"R2 index count ", name}, n_got, N);
    chk(done_cnt == 1, "R2 single done", done_cnt, 1);
    chk(done_cyc == got_cyc[N-1] + 1, "R2 done follows last index", done_cyc, got_cyc[N-1] + 1);
    chk(n_rd == N, "R2 summing read count", n_rd, N);
  endtask

  task automatic t_reset();
    chk(!busy_o && !idx_valid_o && !done_o && !mem_rd_o, "R1 reset outputs",
        int'({busy_o, idx_valid_o, done_o, mem_rd_o}), 0);
  endtask

  task automatic t_mixed();
    int v [N] = '{3, 0, 7, 1, 0, 12, 5, 0, 2, 9, 4, 0, 6};
    for (int i = 0; i < N; i++) wts[i] = v[i];
    run_case("mixed", 0); // R6: zero-weight slots never match the reference
  endtask

  task automatic t_far_heavy();
    for (int i = 0; i < N; i++) wts[i] = (i == 11) ? 200 : 0;
    run_case("far single", 0); // R6 R7 R8: every index is 11, via memory path
  endtask

  task automatic t_near_heavy();
    for (int i = 0; i < N; i++) wts[i] = (i == 2) ? 1 : 0;
    run_case("buffered single", 0);
  endtask

  task automatic t_all_zero();
    for (int i = 0; i < N; i++) wts[i] = 0;
    run_case("all zero", 0); // R5 fallback to last index
  endtask

  task automatic t_restart();
    int v [N] = '{255, 255, 1, 255, 255, 255, 255, 255, 255, 255, 255, 255, 255};
    for (int i = 0; i < N; i++) wts[i] = v[i];
    run_case("restart ignored", 1); // R3, R9 continuing sequence
    chk(!busy_o, "R3 idle after run", int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_far_heavy();
    t_near_heavy();
    t_all_zero();
    t_restart();
    t_mixed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule